// File: doc/BRIEF.md
# Elapsed-Seconds Counter Register File

This block keeps a 32-bit count of elapsed seconds and exposes it, with a control byte and a trickle-charge configuration byte, through a byte-wide register port. A bus front end (an I2C slave, for instance) drives a start strobe with a starting address, then a burst of single-byte reads or writes. An internal address pointer advances after each byte and wraps back to the first location once it passes the last one.

A once-per-second tick pulse advances the counter, but only while the oscillator-disable bit in the control byte is clear. A read burst takes a snapshot of the whole counter when it starts, so a tick that arrives during the burst cannot mix old and new bytes. A write to the counter is collected byte by byte and lands as one 32-bit load on the last counter byte. A power-fail input blocks every access. A backup-power input, together with the control bit, sets the oscillator-run and standby outputs.

Top module: `rtc_seconds_regfile`

## Requirements
- R1: After reset the pointer is 0, the counter is 0, the control and trickle bytes are 00h, `rdata_vld_o` is 0, `osc_run_o` is 1 and `standby_o` is 0.
- R2: The map is: counter byte 0 (least significant) at address 0 up to byte 3 at address 3, control byte at 4, trickle byte at 5. An accepted read gives the addressed byte on `rdata_o`, with `rdata_vld_o` high, on the clock edge after the read strobe.
- R3: An accepted start loads the pointer from `addr_i`, and any address above 5 loads 0. Each accepted read or write advances the pointer by one, and 5 wraps to 0. A read or write strobe in the same cycle as a start is ignored.
- R4: Writes to addresses 0 to 2 are staged and do not change the counter. A write to address 3 loads the counter with {written byte, staged byte 2, staged byte 1, staged byte 0}.
- R5: A one-cycle tick pulse raises the counter by 1 on the second clock edge after the pulse, while control bit 7 is 0. The count wraps from FFFFFFFFh to 0.
- R6: While control bit 7 is 1, ticks leave the counter unchanged.
- R7: An accepted start copies the full counter into a snapshot. Reads of addresses 0 to 3 return the snapshot, so ticks during the burst do not show until the next start.
- R8: A counter load (write to address 3) discards any tick that is pending or arrives in the same cycle.
- R9: While `pwr_fail_i` is 1, start, read and write strobes are ignored. No `rdata_vld_o` is produced and no register or pointer changes.
- R10: `standby_o` is 1 and `osc_run_o` is 0 one edge after `on_backup_i` and control bit 7 are both 1. Otherwise, one edge later, `osc_run_o` is 1 and `standby_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse each second |
| pwr_fail_i | input | 1 | Main supply below trip point; blocks access |
| on_backup_i | input | 1 | Block is running from the backup supply |
| start_i | input | 1 | Start of burst; loads pointer and takes snapshot |
| addr_i | input | 3 | Starting address for a burst |
| wr_i | input | 1 | Write one byte at the pointer |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read one byte at the pointer |
| rdata_o | output | 8 | Registered read data |
| rdata_vld_o | output | 1 | Read data valid, one cycle |
| osc_run_o | output | 1 | Oscillator enable |
| standby_o | output | 1 | Low-power standby request |
| trickle_cfg_o | output | 8 | Trickle-charge configuration byte |

## Verification
Assertions check on every cycle that the pointer stays in range and wraps from 5 to 0, that a pending tick adds exactly one while counting is enabled, that a set oscillator-disable bit freezes the count, that a load clears the pending tick, that power-fail suppresses read-valid, and that run and standby are never both high. Only the bench scenarios can show the byte order of the map, that a staged write lands on the right bytes, that the snapshot hides a tick that arrives mid-burst, and what a read returns after an ignored write under power-fail.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_e;
endpackage

// File: rtl/rtc_ptr.sv
module rtc_ptr #(
  parameter int NUM_LOC = 6,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_ok,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_LOC - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_o <= '0;
    end else if (start_ok) begin
      ptr_o <= (start_addr > LAST) ? '0 : start_addr;
    end else if (step) begin
      ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
    end
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst) ptr_o <= LAST); // R3
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && !start_ok && ptr_o == LAST) |=> ptr_o == '0); // R3
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CNT_BYTES = 4,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tick,
  input  logic                        count_en,
  input  logic                        snap,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [CNT_BYTES*DATA_W-1:0] shadow_o
);
  localparam int CNT_W = CNT_BYTES * DATA_W;
  localparam int STG_N = CNT_BYTES - 1;
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(CNT_BYTES - 1);

  logic [CNT_W-1:0]  count_q;
  logic [CNT_W-1:0]  load_val;
  logic [DATA_W-1:0] stage_q [STG_N];
  logic              pend_q;
  logic              load;
  logic              inc;

  assign load = wr_en && (wr_addr == TOP_ADDR);
  assign inc  = pend_q && count_en && !load;

  generate
    for (genvar g = 0; g < STG_N; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q[g] <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(g)) begin
          stage_q[g] <= wdata;
        end
      end
    end
  endgenerate

  always_comb begin
    load_val = '0;
    for (int k = 0; k < STG_N; k++) begin
      load_val[k*DATA_W +: DATA_W] = stage_q[k];
    end
    load_val[STG_N*DATA_W +: DATA_W] = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (load) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= tick;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= load_val;
    end else if (inc) begin
      count_q <= count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_o <= '0;
    end else if (snap) begin
      shadow_o <= count_q;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (pend_q && count_en && !load) |=> count_q == $past(count_q) + CNT_W'(1)); // R5
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!count_en && !load) |=> $stable(count_q)); // R6
  AST_LOAD_DROPS_TICK: assert property (@(posedge clk) disable iff (rst)
    load |=> !pend_q); // R8
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int CTRL_ADDR = 4,
  parameter int TCS_ADDR  = 5,
  parameter int EOSC_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              on_backup,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] trickle_q,
  output logic              eosc_o,
  output logic              osc_run_o,
  output logic              standby_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] TCS_A  = ADDR_W'(TCS_ADDR);

  assign eosc_o = ctrl_q[EOSC_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      trickle_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == CTRL_A) ctrl_q    <= wdata;
      if (wr_addr == TCS_A)  trickle_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_run_o <= 1'b1;
      standby_o <= 1'b0;
    end else begin
      osc_run_o <= !(on_backup && eosc_o);
      standby_o <= on_backup && eosc_o;
    end
  end

  AST_RUN_XOR_STANDBY: assert property (@(posedge clk) disable iff (rst)
    osc_run_o != standby_o); // R10
endmodule

// File: rtl/rtc_seconds_regfile.sv
module rtc_seconds_regfile #(
  parameter int CNT_BYTES = 4,
  parameter int DATA_W    = 8,
  parameter int EOSC_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              pwr_fail_i,
  input  logic              on_backup_i,
  input  logic              start_i,
  input  logic [2:0]        addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_vld_o,
  output logic              osc_run_o,
  output logic              standby_o,
  output logic [DATA_W-1:0] trickle_cfg_o
);
  import rtc_pkg::*;

  localparam int NUM_LOC   = CNT_BYTES + 2;
  localparam int ADDR_W    = 3;
  localparam int CTRL_ADDR = CNT_BYTES;
  localparam int TCS_ADDR  = CNT_BYTES + 1;
  localparam int CNT_W     = CNT_BYTES * DATA_W;

  logic              start_ok;
  acc_e              acc;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  shadow;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] trickle_q;
  logic              eosc;
  logic [DATA_W-1:0] sel_byte;
  logic              wr_ok;
  logic              rd_ok;

  assign start_ok = start_i && !pwr_fail_i;

  always_comb begin
    acc = ACC_NONE;
    if (!pwr_fail_i && !start_i) begin
      if (wr_i)      acc = ACC_WR;
      else if (rd_i) acc = ACC_RD;
    end
  end

  assign wr_ok = (acc == ACC_WR);
  assign rd_ok = (acc == ACC_RD);

  rtc_ptr #(
    .NUM_LOC (NUM_LOC),
    .ADDR_W  (ADDR_W)
  ) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .start_ok   (start_ok),
    .start_addr (addr_i),
    .step       (wr_ok || rd_ok),
    .ptr_o      (ptr)
  );

  rtc_counter #(
    .CNT_BYTES (CNT_BYTES),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
  ) u_counter (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_i),
    .count_en (!eosc),
    .snap     (start_ok),
    .wr_en    (wr_ok),
    .wr_addr  (ptr),
    .wdata    (wdata_i),
    .shadow_o (shadow)
  );

  rtc_ctrl #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .TCS_ADDR  (TCS_ADDR),
    .EOSC_BIT  (EOSC_BIT)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_ok),
    .wr_addr   (ptr),
    .wdata     (wdata_i),
    .on_backup (on_backup_i),
    .ctrl_q    (ctrl_q),
    .trickle_q (trickle_q),
    .eosc_o    (eosc),
    .osc_run_o (osc_run_o),
    .standby_o (standby_o)
  );

  always_comb begin
    sel_byte = '0;
    for (int k = 0; k < CNT_BYTES; k++) begin
      if (ptr == ADDR_W'(k)) sel_byte = shadow[k*DATA_W +: DATA_W];
    end
    if (ptr == ADDR_W'(CTRL_ADDR)) sel_byte = ctrl_q;
    if (ptr == ADDR_W'(TCS_ADDR))  sel_byte = trickle_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o     <= '0;
      rdata_vld_o <= 1'b0;
    end else begin
      rdata_vld_o <= rd_ok;
      if (rd_ok) rdata_o <= sel_byte;
    end
  end

  assign trickle_cfg_o = trickle_q;

  AST_PF_NO_READ: assert property (@(posedge clk) disable iff (rst)
    pwr_fail_i |=> !rdata_vld_o); // R9
  AST_START_BLOCKS_READ: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !rdata_vld_o); // R3
endmodule

// File: tb/test_rtc_seconds_regfile.sv
module test_rtc_seconds_regfile;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] OP_S = 3'd1, OP_W = 3'd2, OP_R = 3'd3, OP_T = 3'd4, OP_P = 3'd5;
  localparam int NV = 41;
  // fields: {req, op, addr, data, expected}
  localparam logic [25:0] VEC [NV] = '{
    {4'd4, OP_S, 3'd0, 8'h00, 8'h00}, // R4 fill counter and registers
    {4'd4, OP_W, 3'd0, 8'h10, 8'h00},
    {4'd4, OP_W, 3'd0, 8'h20, 8'h00},
    {4'd4, OP_W, 3'd0, 8'h30, 8'h00},
    {4'd4, OP_W, 3'd0, 8'h40, 8'h00},
    {4'd2, OP_W, 3'd0, 8'h00, 8'h00},
    {4'd2, OP_W, 3'd0, 8'hA5, 8'h00},
    {4'd2, OP_S, 3'd0, 8'h00, 8'h00}, // R2 map order
    {4'd2, OP_R, 3'd0, 8'h00, 8'h10},
    {4'd2, OP_R, 3'd0, 8'h00, 8'h20},
    {4'd2, OP_R, 3'd0, 8'h00, 8'h30},
    {4'd2, OP_R, 3'd0, 8'h00, 8'h40},
    {4'd2, OP_R, 3'd0, 8'h00, 8'h00},
    {4'd2, OP_R, 3'd0, 8'h00, 8'hA5},
    {4'd3, OP_R, 3'd0, 8'h00, 8'h10}, // R3 wrap 5 -> 0
    {4'd5, OP_T, 3'd0, 8'h00, 8'h00}, // R5 tick
    {4'd5, OP_S, 3'd0, 8'h00, 8'h00},
    {4'd5, OP_R, 3'd0, 8'h00, 8'h11},
    {4'd5, OP_S, 3'd0, 8'h00, 8'h00}, // R5 wrap of full count
    {4'd5, OP_W, 3'd0, 8'hFF, 8'h00},
    {4'd5, OP_W, 3'd0, 8'hFF, 8'h00},
    {4'd5, OP_W, 3'd0, 8'hFF, 8'h00},
    {4'd5, OP_W, 3'd0, 8'hFF, 8'h00},
    {4'd5, OP_T, 3'd0, 8'h00, 8'h00},
    {4'd5, OP_S, 3'd0, 8'h00, 8'h00},
    {4'd5, OP_R, 3'd0, 8'h00, 8'h00},
    {4'd5, OP_R, 3'd0, 8'h00, 8'h00},
    {4'd5, OP_R, 3'd0, 8'h00, 8'h00},
    {4'd5, OP_R, 3'd0, 8'h00, 8'h00},
    {4'd6, OP_S, 3'd4, 8'h00, 8'h00}, // R6 disable counting
    {4'd6, OP_W, 3'd0, 8'h80, 8'h00},
    {4'd6, OP_T, 3'd0, 8'h00, 8'h00},
    {4'd6, OP_S, 3'd0, 8'h00, 8'h00},
    {4'd6, OP_R, 3'd0, 8'h00, 8'h00},
    {4'd6, OP_S, 3'd4, 8'h00, 8'h00},
    {4'd6, OP_W, 3'd0, 8'h00, 8'h00},
    {4'd9, OP_P, 3'd0, 8'h01, 8'h00}, // R9 write under power-fail
    {4'd9, OP_S, 3'd5, 8'h00, 8'h00},
    {4'd9, OP_W, 3'd0, 8'h11, 8'h00},
    {4'd9, OP_P, 3'd0, 8'h00, 8'h00},
    {4'd9, OP_S, 3'd5, 8'h00, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0, pwr_fail_i = 1'b0, on_backup_i = 1'b0;
  logic       start_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, trickle_cfg_o;
  logic       rdata_vld_o, osc_run_o, standby_o;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_seconds_regfile i_rtc_seconds_regfile (
    .clk(clk), .rst(rst), .tick_i(tick_i), .pwr_fail_i(pwr_fail_i),
    .on_backup_i(on_backup_i), .start_i(start_i), .addr_i(addr_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .rd_i(rd_i), .rdata_o(rdata_o),
    .rdata_vld_o(rdata_vld_o), .osc_run_o(osc_run_o), .standby_o(standby_o),
    .trickle_cfg_o(trickle_cfg_o)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic do_start(input logic [2:0] a);
    start_i = 1'b1; addr_i = a; @(negedge clk); start_i = 1'b0;
  endtask
  task automatic do_wr(input logic [7:0] d);
    wr_i = 1'b1; wdata_i = d; @(negedge clk); wr_i = 1'b0;
  endtask
  task automatic do_rd(input string req, input logic [7:0] exp);
    rd_i = 1'b1; @(negedge clk); rd_i = 1'b0;
    check(req, {rdata_vld_o, rdata_o}, {1'b1, exp});
  endtask
  task automatic do_tick();
    tick_i = 1'b1; @(negedge clk); tick_i = 1'b0; @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    idle(3); rst = 1'b0;
    // R1 reset state
    check("R1 vld", {8'h00, rdata_vld_o}, 9'h000);
    check("R1 osc", {7'h00, osc_run_o, standby_o}, 9'h002);
    check("R1 trickle", {1'b0, trickle_cfg_o}, 9'h000);
    do_rd("R1 pointer/count", 8'h00);
    do_start(3'd4); do_rd("R1 control", 8'h00);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][25:22], i);
      case (VEC[i][21:19])
        OP_S: do_start(VEC[i][18:16]);
        OP_W: do_wr(VEC[i][15:8]);
        OP_R: do_rd(tag, VEC[i][7:0]);
        OP_T: do_tick();
        OP_P: begin pwr_fail_i = VEC[i][8]; @(negedge clk); end
        default: idle(1);
      endcase
    end
    do_rd("R9 trickle untouched", 8'hA5);
    check("R9 trickle port", {1'b0, trickle_cfg_o}, 9'h0A5);

    // R3: start above 5 selects 0
    do_start(3'd7); do_rd("R3 start beyond map", 8'h00);

    // R4: partial staging does not load
    do_start(3'd0); do_wr(8'h55); do_wr(8'h66); do_wr(8'h77);
    do_start(3'd0); do_rd("R4 staged only", 8'h00);

    // R7: snapshot hides mid-burst tick
    do_start(3'd0); do_wr(8'hFF); do_wr(8'h00); do_wr(8'h00); do_wr(8'h00);
    do_start(3'd0); do_rd("R7 byte0", 8'hFF);
    do_tick();
    do_rd("R7 byte1 from snapshot", 8'h00);
    do_start(3'd0); do_rd("R7 new byte0", 8'h00); do_rd("R7 new byte1", 8'h01);

    // R8: pending tick dropped by load in next cycle
    do_start(3'd0); do_wr(8'h78); do_wr(8'h56); do_wr(8'h34);
    tick_i = 1'b1; @(negedge clk); tick_i = 1'b0;
    do_wr(8'h12); idle(2);
    do_start(3'd0); do_rd("R8 pending dropped", 8'h78);
    // R8: tick in same cycle as load
    do_start(3'd0); do_wr(8'h78); do_wr(8'h56); do_wr(8'h34);
    tick_i = 1'b1; do_wr(8'h12); tick_i = 1'b0; idle(2);
    do_start(3'd0); do_rd("R8 same-cycle tick", 8'h78);

    // R3: read with start ignored
    do_start(3'd2);
    start_i = 1'b1; addr_i = 3'd0; rd_i = 1'b1; @(negedge clk);
    start_i = 1'b0; rd_i = 1'b0;
    check("R3 start+read no vld", {8'h00, rdata_vld_o}, 9'h000);
    do_rd("R3 pointer not advanced", 8'h78);

    // R9: read under power-fail
    pwr_fail_i = 1'b1; rd_i = 1'b1; @(negedge clk); rd_i = 1'b0;
    check("R9 no read", {8'h00, rdata_vld_o}, 9'h000);
    pwr_fail_i = 1'b0;
    do_rd("R9 pointer held", 8'h56);

    // R10: standby on backup with oscillator disabled
    do_start(3'd4); do_wr(8'h80);
    on_backup_i = 1'b1; idle(1);
    check("R10 standby", {7'h00, osc_run_o, standby_o}, 9'h001);
    on_backup_i = 1'b0; idle(1);
    check("R10 main power run", {7'h00, osc_run_o, standby_o}, 9'h002);
    do_start(3'd4); do_wr(8'h00);
    on_backup_i = 1'b1; idle(1);
    check("R10 backup enabled", {7'h00, osc_run_o, standby_o}, 9'h002);
    on_backup_i = 1'b0;

    // R1: reset mid-run
    rst = 1'b1; idle(2); rst = 1'b0;
    check("R1 trickle after reset", {1'b0, trickle_cfg_o}, 9'h000);
    do_start(3'd0); do_rd("R1 count cleared", 8'h00);

    summary();
  end
endmodule